// File: doc/BRIEF.md
# Parallel Programming Command Front End

This block is the device-side front end of a parallel programming port for a small controller's nonvolatile stores. A host moves it into programming mode with an entry request while four strobe lines are held low. The host then steps bytes in from an 8-bit data bus. Each rising edge of a load clock puts the bus byte into an address register, a data register or the command register, as a two-bit action code directs. Two byte-select lines pick which byte a load or a fuse access targets.

A rising edge on the page-load strobe copies the 16-bit data word into a small page buffer slot. A falling edge on the active-low write strobe runs the loaded command. The command may commit the page buffer to flash or EEPROM, write a fuse byte, write the lock byte, or erase the chip. A ready flag stays low for a fixed, parameterised number of cycles while an operation runs. While the active-low output enable is low, the block drives back the stored byte that the current command, address and byte selects point at. The stores are plain register files.

Top module: `parprog_port`

## Requirements
- R1: The block leaves reset out of programming mode with `ready` low. It enters the mode only on a cycle where `prog_req` is high while `page_ld`, `act_code[1]`, `act_code[0]` and `bsel1` are all low. In the mode `ready` is high whenever no operation runs, and outside the mode `ready` is never high.
- R2: A rising edge of `xtal_pulse` loads `data_in` according to `act_code`. The code 2'b00 loads an address byte, 2'b01 loads a data byte, 2'b10 loads the command byte, and 2'b11 changes nothing.
- R3: For address and data loads, `bsel1`=0 writes the low byte and `bsel1`=1 writes the high byte. For flash reads, `bsel1` picks the low (0) or the high (1) byte of the addressed word.
- R4: For fuse writes and fuse reads, {`bsel2`,`bsel1`} = 2'b11 selects the extended fuse byte, 2'b01 the high fuse byte, and 2'b00 or 2'b10 the low fuse byte.
- R5: `data_drive` is high only while the block is in the mode and `oe_n` is low. Otherwise the bus is treated as an input.
- R6: A falling edge of `wr_n` starts the loaded command.
- R7: After a started command, `ready` is low for exactly ERASE_CYC cycles for chip erase and for exactly WRITE_CYC cycles for every other command.
- R8: The command byte sets the action, and the data low byte is the value written. 8'h10 commits the page buffer to the flash page holding the loaded address. 8'h11 commits the low bytes of the page buffer to the EEPROM page holding the loaded address. 8'h40 writes the data low byte to the fuse byte chosen per R4. 8'h20 writes the data low byte to the lock byte.
- R9: A rising edge of `page_ld` stores the 16-bit data word {high,low} into page buffer slot (address mod PAGE_WORDS). The buffer resets to 16'hFFFF.
- R10: While `ready` is low, load pulses, page-load edges and write edges have no effect.
- R11: Chip erase (8'h80) sets every flash word to 16'hFFFF, every EEPROM byte to 8'hFF and the lock byte to 8'hFF, and leaves the fuse bytes unchanged.
- R12: A write edge with any other command byte changes nothing and keeps `ready` high.
- R13: While driving, `data_out` returns a byte chosen by the loaded command. Command 8'h10 returns a flash byte (per R3), 8'h11 the EEPROM byte, 8'h40 the selected fuse byte, and 8'h20 the lock byte. An address beyond a store reads 8'hFF, and any other command reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_req | input | 1 | Request to enter programming mode |
| xtal_pulse | input | 1 | Load clock, acts on rising edge |
| act_code | input | 2 | Load action selector |
| bsel1 | input | 1 | Byte select, low/high |
| bsel2 | input | 1 | Second byte select, extended byte with bsel1 |
| page_ld | input | 1 | Page buffer load strobe, acts on rising edge |
| wr_n | input | 1 | Active-low write strobe, acts on falling edge |
| oe_n | input | 1 | Active-low output enable |
| data_in | input | 8 | Bus value seen by the block |
| data_out | output | 8 | Read-back byte |
| data_drive | output | 1 | Bus drive enable |
| ready | output | 1 | High when a new command is accepted |

## Verification
The bench builds the block with a 16-word flash, 4-word pages, an 8-byte EEPROM, an erase time of 20 cycles and a write time of 8 cycles. The 8-cycle window is long enough to fit a command load, a data load and a second write edge inside one busy period, so the bench can show that these are ignored. The small stores let one page commit be checked at its neighbouring slots. The erase and write times differ, so the bench can tell which busy length was applied.

// File: rtl/parprog_pkg.sv
package parprog_pkg;
  typedef enum logic [1:0] {
    ACT_ADDR = 2'b00,
    ACT_DATA = 2'b01,
    ACT_CMD  = 2'b10,
    ACT_IDLE = 2'b11
  } act_e;

  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_FUSE   = 8'h40;
  localparam logic [7:0] CMD_LOCK   = 8'h20;
  localparam logic [7:0] CMD_FLASH  = 8'h10;
  localparam logic [7:0] CMD_EEPROM = 8'h11;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_ERASE) || (c == CMD_FUSE) || (c == CMD_LOCK) ||
           (c == CMD_FLASH) || (c == CMD_EEPROM);
  endfunction

  function automatic int unsigned op_cycles(input logic [7:0] c,
                                            input int unsigned erase_c,
                                            input int unsigned write_c);
    return (c == CMD_ERASE) ? erase_c : write_c;
  endfunction

  function automatic logic [1:0] fuse_slot(input logic b2, input logic b1);
    if (b2 && b1) return 2'd2;
    if (b1)       return 2'd1;
    return 2'd0;
  endfunction
endpackage

// File: rtl/pp_edge.sv
module pp_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= FALLING;
    else        prev_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prev_q & ~lvl;
    end else begin : g_rise
      assign evt = ~prev_q & lvl;
    end
  endgenerate
endmodule

// File: rtl/pp_load_regs.sv
module pp_load_regs
  import parprog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_evt,
  input  logic [1:0]  act_code,
  input  logic        bsel1,
  input  logic [7:0]  din,
  output logic [15:0] addr_q,
  output logic [15:0] data_q,
  output logic [7:0]  cmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
    end else if (ld_evt) begin
      unique case (act_e'(act_code))
        ACT_ADDR: if (bsel1) addr_q[15:8] <= din; else addr_q[7:0] <= din;
        ACT_DATA: if (bsel1) data_q[15:8] <= din; else data_q[7:0] <= din;
        ACT_CMD:  cmd_q <= din;
        ACT_IDLE: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_busy_timer.sv
module pp_busy_timer
  import parprog_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 400,
  parameter int unsigned WRITE_CYC = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] cmd,
  output logic       idle
);
  localparam int unsigned MAXC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= CW'(op_cycles(cmd, ERASE_CYC, WRITE_CYC));
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/pp_nv_store.sv
module pp_nv_store
  import parprog_pkg::*;
#(
  parameter int unsigned FLASH_WORDS = 64,
  parameter int unsigned PAGE_WORDS  = 8,
  parameter int unsigned EE_BYTES    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pg_evt,
  input  logic        start_op,
  input  logic [7:0]  cmd,
  input  logic [15:0] addr,
  input  logic [15:0] data,
  input  logic        bsel1,
  input  logic        bsel2,
  input  logic        rd_en,
  output logic [7:0]  dout,
  output logic        drive
);
  localparam int unsigned FA = $clog2(FLASH_WORDS);
  localparam int unsigned EA = $clog2(EE_BYTES);
  localparam int unsigned PB = $clog2(PAGE_WORDS);

  logic [15:0] flash_m [FLASH_WORDS];
  logic [15:0] pbuf    [PAGE_WORDS];
  logic [7:0]  ee_m    [EE_BYTES];
  logic [7:0]  fuse_m  [3];
  logic [7:0]  lock_q;

  logic flash_hit, ee_hit;
  assign flash_hit = (32'(addr) < FLASH_WORDS);
  assign ee_hit    = (32'(addr) < EE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FLASH_WORDS; i++) flash_m[i] <= 16'hFFFF;
      for (int i = 0; i < PAGE_WORDS; i++)  pbuf[i]    <= 16'hFFFF;
      for (int i = 0; i < EE_BYTES; i++)    ee_m[i]    <= 8'hFF;
      for (int i = 0; i < 3; i++)           fuse_m[i]  <= 8'hFF;
      lock_q <= 8'hFF;
    end else begin
      if (pg_evt) pbuf[addr[PB-1:0]] <= data;
      if (start_op) begin
        unique case (cmd)
          CMD_ERASE: begin
            for (int i = 0; i < FLASH_WORDS; i++) flash_m[i] <= 16'hFFFF;
            for (int i = 0; i < EE_BYTES; i++)    ee_m[i]    <= 8'hFF;
            lock_q <= 8'hFF;
          end
          CMD_FLASH: if (flash_hit)
            for (int i = 0; i < PAGE_WORDS; i++)
              flash_m[{addr[FA-1:PB], PB'(i)}] <= pbuf[i];
          CMD_EEPROM: if (ee_hit)
            for (int i = 0; i < PAGE_WORDS; i++)
              ee_m[{addr[EA-1:PB], PB'(i)}] <= pbuf[i][7:0];
          CMD_FUSE: fuse_m[fuse_slot(bsel2, bsel1)] <= data[7:0];
          CMD_LOCK: lock_q <= data[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (cmd)
      CMD_FLASH:  dout = !flash_hit ? 8'hFF :
                         (bsel1 ? flash_m[addr[FA-1:0]][15:8] : flash_m[addr[FA-1:0]][7:0]);
      CMD_EEPROM: dout = ee_hit ? ee_m[addr[EA-1:0]] : 8'hFF;
      CMD_FUSE:   dout = fuse_m[fuse_slot(bsel2, bsel1)];
      CMD_LOCK:   dout = lock_q;
      default:    dout = 8'h00;
    endcase
  end

  assign drive = rd_en;
endmodule

// File: rtl/parprog_port.sv
module parprog_port
  import parprog_pkg::*;
#(
  parameter int unsigned FLASH_WORDS = 64,
  parameter int unsigned PAGE_WORDS  = 8,
  parameter int unsigned EE_BYTES    = 32,
  parameter int unsigned ERASE_CYC   = 400,
  parameter int unsigned WRITE_CYC   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_req,
  input  logic       xtal_pulse,
  input  logic [1:0] act_code,
  input  logic       bsel1,
  input  logic       bsel2,
  input  logic       page_ld,
  input  logic       wr_n,
  input  logic       oe_n,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_drive,
  output logic       ready
);
  logic        in_mode;
  logic        busy_idle;
  logic        accept;
  logic        xtal_edge, pg_edge, wr_edge;
  logic        ld_evt, pg_evt, start_op;
  logic [15:0] addr_q, data_q;
  logic [7:0]  cmd_q;
  logic        entry_ok;

  assign entry_ok = prog_req && ({page_ld, act_code, bsel1} == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_mode <= 1'b0;
    else if (entry_ok) in_mode <= 1'b1;
  end

  pp_edge #(.FALLING(1'b0)) u_xtal_edge (.clk(clk), .rst_n(rst_n), .lvl(xtal_pulse), .evt(xtal_edge));
  pp_edge #(.FALLING(1'b0)) u_pg_edge   (.clk(clk), .rst_n(rst_n), .lvl(page_ld),    .evt(pg_edge));
  pp_edge #(.FALLING(1'b1)) u_wr_edge   (.clk(clk), .rst_n(rst_n), .lvl(wr_n),       .evt(wr_edge));

  assign accept   = in_mode && busy_idle;
  assign ld_evt   = xtal_edge && accept;
  assign pg_evt   = pg_edge && accept;
  assign start_op = wr_edge && accept && cmd_known(cmd_q);
  assign ready    = accept;

  pp_load_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ld_evt(ld_evt), .act_code(act_code),
    .bsel1(bsel1), .din(data_in), .addr_q(addr_q), .data_q(data_q), .cmd_q(cmd_q)
  );

  pp_busy_timer #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start_op), .cmd(cmd_q), .idle(busy_idle)
  );

  pp_nv_store #(.FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS), .EE_BYTES(EE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .pg_evt(pg_evt), .start_op(start_op), .cmd(cmd_q),
    .addr(addr_q), .data(data_q), .bsel1(bsel1), .bsel2(bsel2),
    .rd_en(in_mode && !oe_n), .dout(data_out), .drive(data_drive)
  );
endmodule

// File: rtl/parprog_sva.sv
module parprog_sva
  import parprog_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       prog_req,
  input logic       page_ld,
  input logic [1:0] act_code,
  input logic       bsel1,
  input logic       oe_n,
  input logic       in_mode,
  input logic       ready,
  input logic       data_drive,
  input logic       start_op,
  input logic       wr_edge,
  input logic [7:0] cmd_q
);
  AST_ENTRY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mode) |-> $past(prog_req && !page_ld && act_code == 2'b00 && !bsel1)); // R1

  AST_READY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> in_mode); // R1

  AST_NO_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !data_drive); // R5

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> !ready); // R7

  AST_UNKNOWN_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_edge && ready && !cmd_known(cmd_q)) |=> ready); // R12

  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && !ready) |=> $stable(cmd_q)); // R10
endmodule

bind parprog_port parprog_sva u_sva (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .page_ld(page_ld),
  .act_code(act_code), .bsel1(bsel1), .oe_n(oe_n), .in_mode(in_mode),
  .ready(ready), .data_drive(data_drive), .start_op(start_op),
  .wr_edge(wr_edge), .cmd_q(cmd_q)
);

// File: tb/parprog_port_tb_top.sv
module parprog_port_tb_top;
  localparam int unsigned ERASE_N = 20;
  localparam int unsigned WRITE_N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_req = 1'b0, xtal_pulse = 1'b0, bsel1 = 1'b0, bsel2 = 1'b0;
  logic       page_ld = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
  logic [1:0] act_code = 2'b11;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_drive, ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  always #2.5 clk = ~clk;

  parprog_port #(
    .FLASH_WORDS(16), .PAGE_WORDS(4), .EE_BYTES(8),
    .ERASE_CYC(ERASE_N), .WRITE_CYC(WRITE_N)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .xtal_pulse(xtal_pulse),
    .act_code(act_code), .bsel1(bsel1), .bsel2(bsel2), .page_ld(page_ld),
    .wr_n(wr_n), .oe_n(oe_n), .data_in(data_in), .data_out(data_out),
    .data_drive(data_drive), .ready(ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per read strobe
  initial forever begin
    @(rd_ev);
    begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(data_drive === 1'b1, {t, " drive"}, int'(data_drive), 1);
      check(data_out === e, t, int'(data_out), int'(e));
    end
  end

  task automatic load(input logic [1:0] a, input logic b1, input logic [7:0] v);
    @(negedge clk);
    act_code = a; bsel1 = b1; bsel2 = 1'b0; data_in = v; xtal_pulse = 1'b1;
    @(negedge clk);
    xtal_pulse = 1'b0; act_code = 2'b11;
  endtask

  task automatic page_pulse();
    @(negedge clk); page_ld = 1'b1;
    @(negedge clk); page_ld = 1'b0;
  endtask

  task automatic write_cmd(output int lows);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    lows = 0;
    while (!ready && lows < 1000) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input logic b2, input logic b1, input logic [7:0] e, input string t);
    @(negedge clk);
    bsel2 = b2; bsel1 = b1; oe_n = 1'b0;
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> rd_ev;
    @(negedge clk);
    oe_n = 1'b1; bsel1 = 1'b0; bsel2 = 1'b0;
  endtask

  initial begin
    int lows;
    int t0;
    repeat (3) @(negedge clk);
    check(ready === 1'b0, "R1 reset ready", int'(ready), 0);
    check(data_drive === 1'b0, "R5 reset drive", int'(data_drive), 0);
    rst_n = 1'b1;
    // entry with bsel1 high must be rejected
    @(negedge clk); prog_req = 1'b1; bsel1 = 1'b1; act_code = 2'b00;
    @(negedge clk); prog_req = 1'b0; bsel1 = 1'b0;
    @(negedge clk);
    check(ready === 1'b0, "R1 bad pattern no entry", int'(ready), 0);
    oe_n = 1'b0;
    @(negedge clk);
    check(data_drive === 1'b0, "R5 no drive outside mode", int'(data_drive), 0);
    oe_n = 1'b1;
    @(negedge clk); prog_req = 1'b1; act_code = 2'b00; page_ld = 1'b0;
    @(negedge clk); prog_req = 1'b0; act_code = 2'b11;
    check(ready === 1'b1, "R1 entry with 0000", int'(ready), 1);
    check(data_drive === 1'b0, "R5 oe high no drive", int'(data_drive), 0);

    // flash page fill and commit (R2 R3 R9 R8 R6 R7)
    load(2'b10, 1'b0, 8'h10);
    load(2'b00, 1'b1, 8'h00);
    load(2'b00, 1'b0, 8'h05);
    load(2'b01, 1'b0, 8'h34);
    load(2'b01, 1'b1, 8'h12);
    page_pulse();
    load(2'b00, 1'b0, 8'h06);
    load(2'b01, 1'b0, 8'h78);
    load(2'b01, 1'b1, 8'h56);
    page_pulse();
    load(2'b00, 1'b0, 8'h05);
    write_cmd(lows);
    check(lows == WRITE_N, "R7 R6 flash busy length", lows, WRITE_N);
    read_chk(1'b0, 1'b0, 8'h34, "R3 R8 R9 flash[5] low");
    read_chk(1'b0, 1'b1, 8'h12, "R3 R13 flash[5] high");
    load(2'b00, 1'b0, 8'h06);
    read_chk(1'b0, 1'b0, 8'h78, "R9 flash[6] low");
    load(2'b00, 1'b0, 8'h04);
    read_chk(1'b0, 1'b1, 8'hFF, "R9 flash[4] untouched slot");
    load(2'b00, 1'b0, 8'h20);
    read_chk(1'b0, 1'b0, 8'hFF, "R13 flash out of range");

    // fuse write to extended byte (R4)
    load(2'b10, 1'b0, 8'h40);
    load(2'b01, 1'b0, 8'hA5);
    @(negedge clk); bsel2 = 1'b1; bsel1 = 1'b1;
    write_cmd(lows);
    bsel2 = 1'b0; bsel1 = 1'b0;
    check(lows == WRITE_N, "R7 fuse busy length", lows, WRITE_N);
    read_chk(1'b1, 1'b1, 8'hA5, "R4 extended fuse");
    read_chk(1'b0, 1'b0, 8'hFF, "R4 low fuse untouched");
    read_chk(1'b1, 1'b0, 8'hFF, "R4 bsel2 alone low fuse");

    // lock write
    load(2'b10, 1'b0, 8'h20);
    load(2'b01, 1'b0, 8'h3C);
    write_cmd(lows);
    read_chk(1'b0, 1'b0, 8'h3C, "R8 lock write");

    // eeprom commit from same page buffer
    load(2'b10, 1'b0, 8'h11);
    load(2'b00, 1'b0, 8'h05);
    write_cmd(lows);
    check(lows == WRITE_N, "R7 eeprom busy length", lows, WRITE_N);
    read_chk(1'b0, 1'b0, 8'h34, "R8 eeprom[5]");
    load(2'b00, 1'b0, 8'h06);
    read_chk(1'b0, 1'b0, 8'h78, "R8 eeprom[6]");

    // idle action code changes nothing
    load(2'b11, 1'b0, 8'h42);
    read_chk(1'b0, 1'b0, 8'h78, "R2 idle action no load");

    // unknown command
    load(2'b10, 1'b0, 8'h55);
    write_cmd(lows);
    check(lows == 0, "R12 unknown cmd stays ready", lows, 0);
    read_chk(1'b0, 1'b0, 8'h00, "R13 unknown cmd reads zero");

    // loads and write edges while busy are ignored (R10)
    load(2'b10, 1'b0, 8'h20);
    load(2'b01, 1'b0, 8'h11);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    t0 = cyc;
    load(2'b10, 1'b0, 8'h10);
    load(2'b01, 1'b0, 8'h99);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    page_pulse();
    while (!ready && (cyc - t0) < 1000) @(negedge clk);
    check((cyc - t0) == WRITE_N, "R10 busy not extended", cyc - t0, WRITE_N);
    read_chk(1'b0, 1'b0, 8'h11, "R10 cmd and data held while busy");

    // chip erase
    load(2'b10, 1'b0, 8'h80);
    write_cmd(lows);
    check(lows == ERASE_N, "R7 erase busy length", lows, ERASE_N);
    load(2'b10, 1'b0, 8'h20);
    read_chk(1'b0, 1'b0, 8'hFF, "R11 lock erased");
    load(2'b10, 1'b0, 8'h10);
    load(2'b00, 1'b0, 8'h05);
    read_chk(1'b0, 1'b1, 8'hFF, "R11 flash erased");
    load(2'b10, 1'b0, 8'h11);
    read_chk(1'b0, 1'b0, 8'hFF, "R11 eeprom erased");
    load(2'b10, 1'b0, 8'h40);
    read_chk(1'b1, 1'b1, 8'hA5, "R11 fuse kept");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule